// File: doc/BRIEF.md
# Bus Cycle Address/Status Multiplexer

This block drives the shared address/status lines of a 16-bit processor bus cycle. A cycle runs through four phases, T1 to T4. In T1 the lines carry the 20-bit address and the active-low high-byte enable. From T2 through T4 the top four lines carry status instead: the code of the segment in use, the live interrupt-enable flag, and a bit held at zero. In those phases the high-byte enable pin carries a spare status bit.

The block also works out which data byte lanes the transfer uses. Even bytes use the low lane (data bits 7..0) and odd bytes use the high lane (data bits 15..8). For I/O cycles the upper four address lines are forced to zero. Direct-form I/O reaches only ports 0..255, so the block also clears address bits 15..8 for it.

A request is accepted on a clock edge where `start_i` is high and the block is idle or in T4. The cycle type, direct flag, width, segment and address are captured on that edge and stay fixed until T4 ends.

Top module: `bus_addr_status_mux`

## Requirements
- R1: While `rst_ni` is low, and in idle after reset, `active_o` is 0, `addr_hi_o` and `addr_lo_o` are 0, `bhe_n_o` is 1 and both lane enables are 0.
- R2: A request accepted on an edge gives T1, T2, T3 and T4 on the next four cycles, with `tstate_o` = 0, 1, 2, 3 and `active_o` = 1. `start_i` is accepted only in idle or T4. A start in T4 gives T1 on the next cycle. A start raised during T1 to T3 has no effect. When T4 ends with no start, the block returns to idle.
- R3: In T1 of a memory cycle, {`addr_hi_o`, `addr_lo_o`} equals the captured 20-bit address.
- R4: In T2 to T4, `addr_hi_o[1:0]` carries the segment code and `addr_lo_o` is 0. The codes are 00 extra data, 01 stack, 10 code or none, 11 data.
- R5: In T2 to T4, `addr_hi_o[2]` equals `ie_flag_i` in that same cycle, and `addr_hi_o[3]` is 0.
- R6: In T1, `bhe_n_o` is the inverse of the high-lane enable. In T2 to T4 it carries the spare status bit, which is driven 1.
- R7: In T1 of an I/O cycle, `addr_hi_o` is 0 and `addr_lo_o` carries the 16-bit port address.
- R8: For an I/O cycle with `io_direct_i` = 1, `addr_lo_o[15:8]` is 0 in T1. For memory cycles `io_direct_i` has no effect.
- R9: The lane enables are set as follows. A byte at an even address sets low only. A byte at an odd address sets high only. A word at an even address sets both. A word at an odd address sets high only. The lanes are valid and unchanged from T1 through T4.
- R10: Changes to `is_io_i`, `io_direct_i`, `word_i`, `seg_i` and `addr_i` after acceptance do not change the outputs of the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a bus cycle |
| is_io_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| io_direct_i | input | 1 | Direct-form I/O (port 0..255) |
| word_i | input | 1 | 1 = word transfer, 0 = byte |
| seg_i | input | 2 | Segment code |
| ie_flag_i | input | 1 | Interrupt-enable flag |
| addr_i | input | 20 | Byte address or port address |
| addr_lo_o | output | 16 | Address lines 15..0 (T1 only) |
| addr_hi_o | output | 4 | Address lines 19..16 in T1, status in T2..T4 |
| bhe_n_o | output | 1 | High-byte enable (T1), spare status (T2..T4) |
| lane_lo_o | output | 1 | Low data lane in use |
| lane_hi_o | output | 1 | High data lane in use |
| active_o | output | 1 | A bus cycle is in progress |
| tstate_o | output | 2 | Current phase, 0..3 for T1..T4 |

## Verification
The assertions check every cycle for the following: the T1-to-T4 order, the status layout in T2 to T4 (interrupt flag mirrored, top bit zero, spare bit high, low lines cleared), a steady segment code and steady lanes through the cycle, the match between the high-byte enable and the high lane in T1, zeroed high lines after an I/O acceptance, and the quiet idle state. Only the bench scenarios show the exact T1 address after I/O and direct-form shaping, the lane choice for each width and alignment, back-to-back cycles, a start ignored in mid-cycle, and inputs changed after acceptance having no effect.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } bus_state_e;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_code_e;

  localparam logic SPARE_STATUS = 1'b1;
endpackage

// File: rtl/bam_seq.sv
module bam_seq
  import bam_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output bus_state_e state_o,
  output logic       accept_o
);
  bus_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE || state_q == ST_T4);

  always_comb begin
    case (state_q)
      ST_IDLE: state_d = accept_o ? ST_T1 : ST_IDLE;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ST_T4;
      ST_T4:   state_d = accept_o ? ST_T1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bam_capture.sv
module bam_capture #(
  parameter int ADDR_W   = 20,
  parameter int IO_W     = 16,
  parameter int DIRECT_W = 8,
  parameter int SEG_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              is_io_i,
  input  logic              direct_i,
  input  logic              word_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic              word_q_o,
  output logic [SEG_W-1:0]  seg_q_o
);
  logic [ADDR_W-1:0] keep;

  // per-bit mask: port space clears high lines, direct form clears mid lines
  for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
    if (i < DIRECT_W) begin : g_lo
      assign keep[i] = 1'b1;
    end else if (i < IO_W) begin : g_mid
      assign keep[i] = !(is_io_i && direct_i);
    end else begin : g_hi
      assign keep[i] = !is_io_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o <= '0;
      word_q_o <= 1'b0;
      seg_q_o  <= '0;
    end else if (accept_i) begin
      addr_q_o <= addr_i & keep;
      word_q_o <= word_i;
      seg_q_o  <= seg_i;
    end
  end
endmodule

// File: rtl/bam_lane.sv
module bam_lane (
  input  logic addr0_i,
  input  logic word_i,
  output logic lane_lo_o,
  output logic lane_hi_o
);
  // odd word: first byte of a split transfer goes on the high lane only
  assign lane_lo_o = !addr0_i;
  assign lane_hi_o = addr0_i || word_i;
endmodule

// File: rtl/bam_outmux.sv
module bam_outmux
  import bam_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IO_W   = 16,
  parameter int SEG_W  = 2
) (
  input  bus_state_e               state_i,
  input  logic [ADDR_W-1:0]        addr_q_i,
  input  logic [SEG_W-1:0]         seg_q_i,
  input  logic                     ie_i,
  input  logic                     lane_lo_i,
  input  logic                     lane_hi_i,
  output logic [IO_W-1:0]          addr_lo_o,
  output logic [ADDR_W-IO_W-1:0]   addr_hi_o,
  output logic                     bhe_n_o,
  output logic                     lane_lo_o,
  output logic                     lane_hi_o,
  output logic                     active_o,
  output logic [1:0]               tstate_o
);
  localparam int HI_W = ADDR_W - IO_W;

  logic [HI_W-1:0] status;

  always_comb begin
    status = '0;
    status[SEG_W-1:0] = seg_q_i;
    status[SEG_W]     = ie_i;
  end

  always_comb begin
    addr_lo_o = '0;
    addr_hi_o = '0;
    bhe_n_o   = 1'b1;
    lane_lo_o = 1'b0;
    lane_hi_o = 1'b0;
    active_o  = 1'b0;
    tstate_o  = 2'd0;
    case (state_i)
      ST_T1: begin
        addr_lo_o = addr_q_i[IO_W-1:0];
        addr_hi_o = addr_q_i[ADDR_W-1:IO_W];
        bhe_n_o   = !lane_hi_i;
        lane_lo_o = lane_lo_i;
        lane_hi_o = lane_hi_i;
        active_o  = 1'b1;
        tstate_o  = 2'd0;
      end
      ST_T2, ST_T3, ST_T4: begin
        addr_hi_o = status;
        bhe_n_o   = SPARE_STATUS;
        lane_lo_o = lane_lo_i;
        lane_hi_o = lane_hi_i;
        active_o  = 1'b1;
        tstate_o  = (state_i == ST_T2) ? 2'd1 : (state_i == ST_T3) ? 2'd2 : 2'd3;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_addr_status_mux.sv
module bus_addr_status_mux
  import bam_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int IO_W     = 16,
  parameter int DIRECT_W = 8,
  parameter int SEG_W    = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   is_io_i,
  input  logic                   io_direct_i,
  input  logic                   word_i,
  input  logic [SEG_W-1:0]       seg_i,
  input  logic                   ie_flag_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [IO_W-1:0]        addr_lo_o,
  output logic [ADDR_W-IO_W-1:0] addr_hi_o,
  output logic                   bhe_n_o,
  output logic                   lane_lo_o,
  output logic                   lane_hi_o,
  output logic                   active_o,
  output logic [1:0]             tstate_o
);
  bus_state_e        state;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic              word_q;
  logic [SEG_W-1:0]  seg_q;
  logic              lane_lo, lane_hi;

  bam_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .state_o  (state),
    .accept_o (accept)
  );

  bam_capture #(
    .ADDR_W   (ADDR_W),
    .IO_W     (IO_W),
    .DIRECT_W (DIRECT_W),
    .SEG_W    (SEG_W)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .is_io_i  (is_io_i),
    .direct_i (io_direct_i),
    .word_i   (word_i),
    .seg_i    (seg_i),
    .addr_i   (addr_i),
    .addr_q_o (addr_q),
    .word_q_o (word_q),
    .seg_q_o  (seg_q)
  );

  bam_lane u_lane (
    .addr0_i   (addr_q[0]),
    .word_i    (word_q),
    .lane_lo_o (lane_lo),
    .lane_hi_o (lane_hi)
  );

  bam_outmux #(
    .ADDR_W (ADDR_W),
    .IO_W   (IO_W),
    .SEG_W  (SEG_W)
  ) u_mux (
    .state_i   (state),
    .addr_q_i  (addr_q),
    .seg_q_i   (seg_q),
    .ie_i      (ie_flag_i),
    .lane_lo_i (lane_lo),
    .lane_hi_i (lane_hi),
    .addr_lo_o (addr_lo_o),
    .addr_hi_o (addr_hi_o),
    .bhe_n_o   (bhe_n_o),
    .lane_lo_o (lane_lo_o),
    .lane_hi_o (lane_hi_o),
    .active_o  (active_o),
    .tstate_o  (tstate_o)
  );
endmodule

// File: rtl/bam_checker.sv
module bam_checker
  import bam_pkg::*;
#(
  parameter int IO_W = 16,
  parameter int HI_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input bus_state_e      state_i,
  input logic            accept_i,
  input logic            is_io_i,
  input logic            ie_flag_i,
  input logic [IO_W-1:0] addr_lo_o,
  input logic [HI_W-1:0] addr_hi_o,
  input logic            bhe_n_o,
  input logic            lane_lo_o,
  input logic            lane_hi_o
);
  logic in_status;
  assign in_status = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_T4);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |-> (addr_hi_o == '0 && addr_lo_o == '0 && bhe_n_o && !lane_lo_o && !lane_hi_o));

  p_accept_t1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> state_i == ST_T1);

  p_t1_t2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_T1 |=> state_i == ST_T2);

  p_t2_t3_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_T2 |=> state_i == ST_T3);

  p_t3_t4_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_T3 |=> state_i == ST_T4);

  p_lo_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_status |-> addr_lo_o == '0);

  p_seg_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_T3 || state_i == ST_T4) |-> $stable(addr_hi_o[1:0]));

  p_ie_mirror_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_status |-> (addr_hi_o[2] == ie_flag_i && addr_hi_o[HI_W-1] == 1'b0));

  p_spare_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_status |-> bhe_n_o);

  p_bhe_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_T1 |-> bhe_n_o == !lane_hi_o);

  p_io_hi_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && is_io_i) |=> addr_hi_o == '0);

  p_lane_some_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != ST_IDLE |-> (lane_lo_o || lane_hi_o));

  p_lane_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_status |-> $stable({lane_lo_o, lane_hi_o}));
endmodule

bind bus_addr_status_mux bam_checker #(
  .IO_W (IO_W),
  .HI_W (ADDR_W - IO_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state_i   (state),
  .accept_i  (accept),
  .is_io_i   (is_io_i),
  .ie_flag_i (ie_flag_i),
  .addr_lo_o (addr_lo_o),
  .addr_hi_o (addr_hi_o),
  .bhe_n_o   (bhe_n_o),
  .lane_lo_o (lane_lo_o),
  .lane_hi_o (lane_hi_o)
);

// File: tb/bus_addr_status_mux_test.sv
`timescale 1ns/1ps
module bus_addr_status_mux_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        is_io_i = 1'b0;
  logic        io_direct_i = 1'b0;
  logic        word_i = 1'b0;
  logic [1:0]  seg_i = 2'b00;
  logic        ie_flag_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [15:0] addr_lo_o;
  logic [3:0]  addr_hi_o;
  logic        bhe_n_o, lane_lo_o, lane_hi_o, active_o;
  logic [1:0]  tstate_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_addr_status_mux uut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .is_io_i (is_io_i),
    .io_direct_i (io_direct_i), .word_i (word_i), .seg_i (seg_i),
    .ie_flag_i (ie_flag_i), .addr_i (addr_i), .addr_lo_o (addr_lo_o),
    .addr_hi_o (addr_hi_o), .bhe_n_o (bhe_n_o), .lane_lo_o (lane_lo_o),
    .lane_hi_o (lane_hi_o), .active_o (active_o), .tstate_o (tstate_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic io, input logic dir, input logic wd,
                        input logic [1:0] sg, input logic [19:0] ad);
    @(negedge clk);
    is_io_i = io; io_direct_i = dir; word_i = wd; seg_i = sg; addr_i = ad;
    start_i = 1'b1;
  endtask

  // runs T1..T4 of a cycle whose start is already raised
  task automatic body(input logic io, input logic dir, input logic wd,
                      input logic [1:0] sg, input logic [19:0] ad,
                      input logic poke, input logic arm,
                      input logic io2, input logic dir2, input logic wd2,
                      input logic [1:0] sg2, input logic [19:0] ad2);
    logic [19:0] ea;
    logic el, eh;
    ea = io ? (dir ? {12'h000, ad[7:0]} : {4'h0, ad[15:0]}) : ad;
    el = ~ad[0];
    eh = ad[0] | wd;
    @(negedge clk);
    start_i = 1'b0;
    is_io_i = ~io; io_direct_i = ~dir; word_i = ~wd; seg_i = ~sg; addr_i = ~ad;
    #1;
    chk("R2 T1 phase", {29'd0, active_o, tstate_o}, {29'd0, 1'b1, 2'd0});
    chk("R3 R7 R8 R10 T1 address", {12'd0, addr_hi_o, addr_lo_o}, {12'd0, ea});
    chk("R6 T1 bhe_n", {31'd0, bhe_n_o}, {31'd0, ~eh});
    chk("R9 R10 T1 lanes", {30'd0, lane_lo_o, lane_hi_o}, {30'd0, el, eh});
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      start_i = (poke && k == 1);
      ie_flag_i = (k == 2) ? ~ad[1] : ad[1];
      #1;
      chk("R2 phase", {29'd0, active_o, tstate_o}, {29'd0, 1'b1, k[1:0]});
      chk("R4 R5 status lines", {28'd0, addr_hi_o}, {28'd0, 1'b0, ie_flag_i, sg});
      chk("R4 low lines cleared", {16'd0, addr_lo_o}, 32'd0);
      chk("R6 spare status", {31'd0, bhe_n_o}, 32'd1);
      chk("R9 lanes held", {30'd0, lane_lo_o, lane_hi_o}, {30'd0, el, eh});
    end
    if (arm) begin
      is_io_i = io2; io_direct_i = dir2; word_i = wd2; seg_i = sg2; addr_i = ad2;
      start_i = 1'b1;
    end
  endtask

  task automatic expect_idle(input string tag);
    @(negedge clk);
    #1;
    chk({tag, " R2 idle"}, {31'd0, active_o}, 32'd0);
    chk({tag, " R1 idle outputs"}, {11'd0, addr_hi_o, addr_lo_o, bhe_n_o},
        {11'd0, 20'd0, 1'b1});
    chk({tag, " R1 idle lanes"}, {30'd0, lane_lo_o, lane_hi_o}, 32'd0);
  endtask

  task automatic run_one(input logic io, input logic dir, input logic wd,
                         input logic [1:0] sg, input logic [19:0] ad, input logic poke);
    launch(io, dir, wd, sg, ad);
    body(io, dir, wd, sg, ad, poke, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 20'd0);
    expect_idle("after cycle");
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset active", {31'd0, active_o}, 32'd0);
    chk("R1 reset lines", {11'd0, addr_hi_o, addr_lo_o, bhe_n_o}, {11'd0, 20'd0, 1'b1});
    chk("R1 reset lanes", {30'd0, lane_lo_o, lane_hi_o}, 32'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    expect_idle("post reset");
  endtask

  task automatic t_mem_word_even;     run_one(1'b0, 1'b0, 1'b1, 2'b11, 20'hA5C3E, 1'b0); endtask
  task automatic t_mem_byte_odd;      run_one(1'b0, 1'b0, 1'b0, 2'b01, 20'h12345, 1'b0); endtask
  task automatic t_mem_byte_even;     run_one(1'b0, 1'b0, 1'b0, 2'b00, 20'hF0F02, 1'b0); endtask
  task automatic t_mem_word_odd;      run_one(1'b0, 1'b0, 1'b1, 2'b10, 20'h0ABC7, 1'b0); endtask
  task automatic t_io_register;       run_one(1'b1, 1'b0, 1'b0, 2'b10, 20'hFBEEF, 1'b0); endtask
  task automatic t_io_direct;         run_one(1'b1, 1'b1, 1'b0, 2'b11, 20'h93456, 1'b0); endtask
  task automatic t_io_word_direct;    run_one(1'b1, 1'b1, 1'b1, 2'b00, 20'h7FFC8, 1'b0); endtask
  task automatic t_direct_ignored_r8; run_one(1'b0, 1'b1, 1'b1, 2'b01, 20'hCAFE4, 1'b0); endtask
  task automatic t_start_midcycle_r2; run_one(1'b0, 1'b0, 1'b0, 2'b10, 20'h55AA1, 1'b1); endtask

  task automatic t_back_to_back_r2;
    launch(1'b0, 1'b0, 1'b1, 2'b11, 20'h3C3C0);
    body(1'b0, 1'b0, 1'b1, 2'b11, 20'h3C3C0, 1'b0, 1'b1,
         1'b1, 1'b0, 1'b0, 2'b01, 20'hE1233);
    body(1'b1, 1'b0, 1'b0, 2'b01, 20'hE1233, 1'b0, 1'b0,
         1'b0, 1'b0, 1'b0, 2'b00, 20'd0);
    expect_idle("after back to back");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mem_word_even();
    t_mem_byte_odd();
    t_mem_byte_even();
    t_mem_word_odd();
    t_io_register();
    t_io_direct();
    t_io_word_direct();
    t_direct_ignored_r8();
    t_start_midcycle_r2();
    t_back_to_back_r2();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule